// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block draws into a linear 8-bit-per-pixel framebuffer held in a single-port memory. A host programs a small set of write-only registers (operation, raster operation, rectangle size, row stride, colour, two base addresses and a source corner), then writes the destination corner to the launch register, which starts the job. The engine then walks every pixel of the rectangle on its own, issuing one memory request at a time, and drops its busy flag when the final write has been accepted.

Two jobs exist. A fill either stores the colour register into each pixel or replaces each pixel with its old value XOR the colour. A copy moves a rectangle of pixels from a source corner to a destination corner. The scan direction is chosen per axis from the two corners, so a copy whose source and destination overlap gives the same picture as if the source had been snapshotted first. Corner coordinates up to 16 bits wide are accepted; a coordinate whose span passes 4095 is folded into the base address before the walk starts, which leaves the pixel addresses unchanged.

While busy, the register port stalls the host by lowering its ready signal, so the parameters the engine reads cannot change under it.

Top module: `rect_engine`

## Requirements
- R1: After reset the engine is idle: busy is low, reg_ready is high and no memory request is raised.
- R2: A launch write (address 7, x in bits [15:0], y in bits [31:16]) with non-zero width and height sets busy from the next cycle; reg_ready is low whenever busy is high; busy falls in the cycle after the grant of the last pixel write.
- R3: Register writes are accepted only when reg_ready is high; a write presented while busy takes no effect until busy falls, so the running job keeps its old parameters. Register addresses: 0 command (bit 0: 0 fill, 1 copy; bits [31:24] raster operation), 1 size (width [15:0], height [31:16]), 2 stride in pixels [13:0], 3 colour [7:0], 4 source base, 5 destination base, 6 source corner (x [15:0], y [31:16]).
- R4: A fill whose raster operation is not 8'h66 writes the colour to every pixel at destination base + y × stride + x of the rectangle, with exactly one write and no read per pixel, and touches no other address.
- R5: A fill with raster operation 8'h66 replaces every pixel of the rectangle with its previous value XOR the colour, using exactly one read and one write per pixel.
- R6: A copy gives every destination pixel the value its source pixel held before the job started, also when the two rectangles overlap, using exactly one read and one write per pixel.
- R7: In a copy, columns are walked from x + width − 1 downward when source x ≤ destination x, otherwise upward; rows are walked from y + height − 1 downward when source y ≤ destination y, otherwise upward; a fill always starts at its top-left corner.
- R8: A launch with zero width or zero height makes no memory request and leaves busy low.
- R9: Addresses are formed modulo 2^AW; a corner whose coordinate plus extent exceeds 4095 reaches the same addresses as the unfolded formula.
- R10: A memory request that is not granted is held with unchanged address and direction until granted; read data is taken in the cycle mem_rvalid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | DW | Register write data |
| reg_ready | output | 1 | High when a register write can be accepted |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write (high) or read (low) |
| mem_addr | output | AW | Pixel address |
| mem_wdata | output | PW | Pixel write data |
| mem_gnt | input | 1 | Memory accepts the current request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | PW | Read pixel data |
| busy | output | 1 | Job in progress |

## Verification
The host's register port and the engine's last pixel write can meet in one cycle: a colour write held back by the stalled port becomes acceptable at the moment the final write is granted. The bench provokes this by presenting a colour write right after a launch and keeping it pending until ready returns, under a memory that withholds grant in a fixed rhythm. It judges the outcome from memory contents: every pixel of the running fill must carry the old colour, and the next launch must use the new one.

// File: rtl/rect_pkg.sv
package rect_pkg;

    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_RD    = 2'd1,
        W_RWAIT = 2'd2,
        W_WR    = 2'd3
    } walk_state_e;

    localparam logic [7:0] ROP_XOR = 8'h66;

    localparam logic [2:0] RA_CMD   = 3'd0;
    localparam logic [2:0] RA_SIZE  = 3'd1;
    localparam logic [2:0] RA_PITCH = 3'd2;
    localparam logic [2:0] RA_COLOR = 3'd3;
    localparam logic [2:0] RA_SBASE = 3'd4;
    localparam logic [2:0] RA_DBASE = 3'd5;
    localparam logic [2:0] RA_SXY   = 3'd6;
    localparam logic [2:0] RA_GO    = 3'd7;

endpackage

// File: rtl/rect_origin.sv
module rect_origin #(
    parameter int AW  = 24,
    parameter int CW  = 16,
    parameter int SW  = 14,
    parameter int LIM = 4095
) (
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] x,
    input  logic [CW-1:0] y,
    input  logic [CW-1:0] w,
    input  logic [CW-1:0] h,
    input  logic [SW-1:0] stride,
    input  logic          rev_x,
    input  logic          rev_y,
    output logic [AW-1:0] start
);
    localparam logic [CW:0] LIMIT = (CW+1)'(LIM);

    logic          fold_x, fold_y;
    logic [AW-1:0] base_x, base_xy, col, row;

    always_comb begin
        fold_x  = ({1'b0, x} + {1'b0, w}) > LIMIT;
        fold_y  = ({1'b0, y} + {1'b0, h}) > LIMIT;
        base_x  = base + (fold_x ? AW'(x) : '0);
        base_xy = base_x + (fold_y ? AW'(y) * AW'(stride) : '0);
        col     = fold_x ? '0 : AW'(x);
        row     = fold_y ? '0 : AW'(y);
        if (rev_x) col = col + AW'(w) - AW'(1);
        if (rev_y) row = row + AW'(h) - AW'(1);
        start   = base_xy + row * AW'(stride) + col;
    end
endmodule

// File: rtl/rect_walker.sv
module rect_walker
    import rect_pkg::*;
#(
    parameter int AW = 24,
    parameter int CW = 16,
    parameter int SW = 14,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          is_copy,
    input  logic          is_xor,
    input  logic [CW-1:0] w,
    input  logic [CW-1:0] h,
    input  logic [SW-1:0] stride,
    input  logic [PW-1:0] color,
    input  logic [AW-1:0] dst0,
    input  logic [AW-1:0] src0,
    input  logic          rev_x,
    input  logic          rev_y,
    output logic          busy,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [PW-1:0] mem_wdata,
    input  logic          mem_gnt,
    input  logic          mem_rvalid,
    input  logic [PW-1:0] mem_rdata
);
    typedef struct packed {
        walk_state_e   st;
        logic [AW-1:0] drow;
        logic [AW-1:0] srow;
        logic [CW-1:0] cx;
        logic [CW-1:0] cy;
        logic          rx;
        logic          ry;
        logic [PW-1:0] pix;
    } walk_t;

    walk_t         q, d;
    logic [AW-1:0] dcol, scol, step;
    logic          need_rd;
    walk_state_e   pix_first;

    always_comb begin
        d         = q;
        need_rd   = is_copy | is_xor;
        pix_first = need_rd ? W_RD : W_WR;
        dcol      = q.rx ? q.drow - AW'(q.cx) : q.drow + AW'(q.cx);
        scol      = q.rx ? q.srow - AW'(q.cx) : q.srow + AW'(q.cx);
        step      = q.ry ? AW'(0) - AW'(stride) : AW'(stride);
        busy      = (q.st != W_IDLE);
        mem_req   = (q.st == W_RD) || (q.st == W_WR);
        mem_we    = (q.st == W_WR);
        mem_addr  = (q.st == W_RD && is_copy) ? scol : dcol;
        mem_wdata = is_copy ? q.pix : (is_xor ? (q.pix ^ color) : color);
        unique case (q.st)
            W_IDLE: if (start) begin
                d.st   = pix_first;
                d.drow = dst0;
                d.srow = src0;
                d.cx   = '0;
                d.cy   = '0;
                d.rx   = rev_x;
                d.ry   = rev_y;
            end
            W_RD: if (mem_gnt) d.st = W_RWAIT;
            W_RWAIT: if (mem_rvalid) begin
                d.pix = mem_rdata;
                d.st  = W_WR;
            end
            W_WR: if (mem_gnt) begin
                d.st = pix_first;
                if (q.cx == CW'(w - CW'(1))) begin
                    d.cx = '0;
                    if (q.cy == CW'(h - CW'(1))) begin
                        d.st = W_IDLE;
                    end else begin
                        d.cy   = q.cy + CW'(1);
                        d.drow = q.drow + step;
                        d.srow = q.srow + step;
                    end
                end else begin
                    d.cx = q.cx + CW'(1);
                end
            end
            default: d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R10: an ungranted request stays put
    p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R2: busy ends only after a granted write
    p_fall_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(mem_req && mem_we && mem_gnt));
endmodule

// File: rtl/rect_engine.sv
module rect_engine
    import rect_pkg::*;
#(
    parameter int AW  = 24,
    parameter int DW  = 32,
    parameter int CW  = 16,
    parameter int SW  = 14,
    parameter int PW  = 8,
    parameter int LIM = 4095
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic          reg_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [PW-1:0] mem_wdata,
    input  logic          mem_gnt,
    input  logic          mem_rvalid,
    input  logic [PW-1:0] mem_rdata,
    output logic          busy
);
    typedef struct packed {
        logic          copy;
        logic [7:0]    rop;
        logic [CW-1:0] w;
        logic [CW-1:0] h;
        logic [SW-1:0] stride;
        logic [PW-1:0] color;
        logic [AW-1:0] sbase;
        logic [AW-1:0] dbase;
        logic [CW-1:0] sx;
        logic [CW-1:0] sy;
    } cfg_t;

    cfg_t          q, d;
    logic          accept, go, size_ok, start, rev_x, rev_y, is_xor;
    logic [CW-1:0] dx, dy;
    logic [AW-1:0] dst0, src0;

    always_comb begin
        d         = q;
        reg_ready = !busy;
        accept    = reg_we && reg_ready;
        go        = accept && (reg_addr == RA_GO);
        dx        = reg_wdata[CW-1:0];
        dy        = reg_wdata[2*CW-1:CW];
        size_ok   = (q.w != '0) && (q.h != '0);
        start     = go && size_ok;
        rev_x     = q.copy && (q.sx <= dx);
        rev_y     = q.copy && (q.sy <= dy);
        is_xor    = !q.copy && (q.rop == ROP_XOR);
        if (accept) begin
            unique case (reg_addr)
                RA_CMD: begin
                    d.copy = reg_wdata[0];
                    d.rop  = reg_wdata[DW-1 -: 8];
                end
                RA_SIZE: begin
                    d.w = reg_wdata[CW-1:0];
                    d.h = reg_wdata[2*CW-1:CW];
                end
                RA_PITCH: d.stride = reg_wdata[SW-1:0];
                RA_COLOR: d.color  = reg_wdata[PW-1:0];
                RA_SBASE: d.sbase  = reg_wdata[AW-1:0];
                RA_DBASE: d.dbase  = reg_wdata[AW-1:0];
                RA_SXY: begin
                    d.sx = reg_wdata[CW-1:0];
                    d.sy = reg_wdata[2*CW-1:CW];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    rect_origin #(.AW(AW), .CW(CW), .SW(SW), .LIM(LIM)) u_dst_org (
        .base(q.dbase), .x(dx), .y(dy), .w(q.w), .h(q.h), .stride(q.stride),
        .rev_x(rev_x), .rev_y(rev_y), .start(dst0)
    );

    rect_origin #(.AW(AW), .CW(CW), .SW(SW), .LIM(LIM)) u_src_org (
        .base(q.sbase), .x(q.sx), .y(q.sy), .w(q.w), .h(q.h), .stride(q.stride),
        .rev_x(rev_x), .rev_y(rev_y), .start(src0)
    );

    rect_walker #(.AW(AW), .CW(CW), .SW(SW), .PW(PW)) u_walk (
        .clk(clk), .rst_n(rst_n), .start(start),
        .is_copy(q.copy), .is_xor(is_xor),
        .w(q.w), .h(q.h), .stride(q.stride), .color(q.color),
        .dst0(dst0), .src0(src0), .rev_x(rev_x), .rev_y(rev_y),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    // R2: a launch with a real rectangle starts the job
    p_launch_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_ready && reg_addr == RA_GO && q.w != '0 && q.h != '0) |=> busy);

    // R8: an empty rectangle never starts
    p_zero_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_ready && reg_addr == RA_GO && (q.w == '0 || q.h == '0)) |=> !busy);

    // R3: parameters frozen while a job runs
    p_regs_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(q));
endmodule

// File: tb/sim_rect_engine.sv
module sim_rect_engine;
    localparam int AW = 24;
    localparam int MSZ = 4096;
    localparam int PITCH = 64;

    typedef struct packed {
        logic        op;
        logic        xr;
        logic [15:0] w;
        logic [15:0] h;
        logic [15:0] sx;
        logic [15:0] sy;
        logic [15:0] dx;
        logic [15:0] dy;
        logic [7:0]  c;
        logic [23:0] sb;
        logic [23:0] db;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 16'd5, 16'd3, 16'd0,  16'd0,  16'd2,    16'd1,    8'hA5, 24'd0, 24'd0},
        '{1'b0, 1'b1, 16'd4, 16'd4, 16'd0,  16'd0,  16'd10,   16'd5,    8'hFF, 24'd0, 24'd0},
        '{1'b1, 1'b0, 16'd6, 16'd2, 16'd0,  16'd0,  16'd20,   16'd20,   8'h00, 24'd0, 24'd0},
        '{1'b1, 1'b0, 16'd8, 16'd6, 16'd4,  16'd4,  16'd6,    16'd5,    8'h00, 24'd0, 24'd0},
        '{1'b1, 1'b0, 16'd8, 16'd5, 16'd10, 16'd10, 16'd7,    16'd8,    8'h00, 24'd0, 24'd0},
        '{1'b1, 1'b0, 16'd6, 16'd4, 16'd3,  16'd12, 16'd5,    16'd10,   8'h00, 24'd0, 24'd0},
        '{1'b0, 1'b1, 16'd1, 16'd1, 16'd0,  16'd0,  16'd63,   16'd63,   8'h3C, 24'd0, 24'd0},
        '{1'b0, 1'b0, 16'd4, 16'd2, 16'd0,  16'd0,  16'd4094, 16'd2,    8'h5A, 24'd0, 24'(100 - 4094)},
        '{1'b1, 1'b0, 16'd3, 16'd2, 16'd1,  16'd1,  16'd3,    16'd4094, 8'h00, 24'd0, 24'(300 - 4094 * 64)}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic          reg_ready;
    logic          mem_req, mem_we, mem_gnt, busy;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          mem_rvalid = 1'b0;
    logic [7:0]    mem_rdata = '0;

    logic [7:0]    mem [MSZ];
    logic [7:0]    expm [MSZ];
    logic          preload = 1'b0;
    int            seed = 0;
    int            cyc = 0;
    int            nwr = 0, nrd = 0, oob = 0, hold_err = 0;
    logic          fw_set = 1'b0;
    logic [AW-1:0] fw_addr = '0;
    logic          pend = 1'b0;
    logic [AW-1:0] pend_addr = '0;
    logic          pend_we = 1'b0;
    int            n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    assign mem_gnt = (cyc % 3) != 2;

    rect_engine u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ready(reg_ready), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .busy(busy)
    );

    function automatic logic [7:0] pat(int k, int s);
        return 8'((k * 7 + s * 29 + (k >> 6) * 3) & 255);
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (preload) begin
            for (int k = 0; k < MSZ; k++) mem[k] <= pat(k, seed);
            nwr <= 0; nrd <= 0; fw_set <= 1'b0; mem_rvalid <= 1'b0; pend <= 1'b0;
        end else begin
            mem_rvalid <= 1'b0;
            if (pend && (!mem_req || mem_addr != pend_addr || mem_we != pend_we))
                hold_err <= hold_err + 1;
            pend      <= mem_req && !mem_gnt;
            pend_addr <= mem_addr;
            pend_we   <= mem_we;
            if (mem_req && mem_gnt) begin
                if (mem_addr >= AW'(MSZ)) oob <= oob + 1;
                if (mem_we) begin
                    mem[mem_addr[11:0]] <= mem_wdata;
                    nwr <= nwr + 1;
                    if (!fw_set) begin
                        fw_set  <= 1'b1;
                        fw_addr <= mem_addr;
                    end
                end else begin
                    mem_rdata  <= mem[mem_addr[11:0]];
                    mem_rvalid <= 1'b1;
                    nrd <= nrd + 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        while (!reg_ready) @(negedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic load(input int s);
        @(negedge clk);
        seed = s; preload = 1'b1;
        @(negedge clk);
        preload = 1'b0;
        for (int k = 0; k < MSZ; k++) expm[k] = pat(k, s);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic run_vec(input vec_t v, input int s, input string req);
        logic [7:0]    pre [MSZ];
        logic [AW-1:0] da, sa, fa;
        int            bad, first_bad, fx, fy, rw;
        logic          rx, ry;
        load(s);
        for (int k = 0; k < MSZ; k++) pre[k] = expm[k];
        bad = 0;
        for (int j = 0; j < int'(v.h); j++) begin
            for (int i = 0; i < int'(v.w); i++) begin
                da = v.db + AW'((int'(v.dy) + j) * PITCH) + AW'(int'(v.dx) + i);
                sa = v.sb + AW'((int'(v.sy) + j) * PITCH) + AW'(int'(v.sx) + i);
                if (da >= AW'(MSZ) || sa >= AW'(MSZ)) bad++;
                else if (v.op) expm[da[11:0]] = pre[sa[11:0]];
                else expm[da[11:0]] = v.xr ? (pre[da[11:0]] ^ v.c) : v.c;
            end
        end
        chk(bad == 0, "R9", "vector stays inside bench memory", bad, 0);
        wr(3'd0, {(v.xr ? 8'h66 : 8'hCC), 23'd0, v.op});
        wr(3'd1, {v.h, v.w});
        wr(3'd2, 32'(PITCH));
        wr(3'd3, {24'd0, v.c});
        wr(3'd4, {8'd0, v.sb});
        wr(3'd5, {8'd0, v.db});
        wr(3'd6, {v.sy, v.sx});
        wr(3'd7, {v.dy, v.dx});
        chk(busy == 1'b1, "R2", "busy after launch", busy, 1);
        wait_idle();
        @(negedge clk);
        first_bad = -1;
        for (int k = 0; k < MSZ; k++)
            if (mem[k] !== expm[k] && first_bad < 0) first_bad = k;
        chk(first_bad < 0, req, "framebuffer contents",
            first_bad < 0 ? 0 : mem[first_bad], first_bad < 0 ? 0 : expm[first_bad]);
        rw = (v.op || v.xr) ? int'(v.w) * int'(v.h) : 0;
        chk(nwr == int'(v.w) * int'(v.h), req, "write count", nwr, int'(v.w) * int'(v.h));
        chk(nrd == rw, req, "read count", nrd, rw);
        rx = v.op && (v.sx <= v.dx);
        ry = v.op && (v.sy <= v.dy);
        fx = rx ? int'(v.dx) + int'(v.w) - 1 : int'(v.dx);
        fy = ry ? int'(v.dy) + int'(v.h) - 1 : int'(v.dy);
        fa = v.db + AW'(fy * PITCH) + AW'(fx);
        chk(fw_addr == fa, "R7", "first write address", fw_addr, fa);
    endtask

    initial begin
        int lim;
        lim = 150000;
        while (cyc < lim) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, lim);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
        chk(reg_ready == 1'b1, "R1", "ready in reset", reg_ready, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(mem_req == 1'b0 && busy == 1'b0, "R1", "idle after reset", {mem_req, busy}, 0);

        // table walk: R4 plain fill, R5 xor fill, R6 copies, R9 folded corners
        for (int i = 0; i < NV; i++) begin
            string rq;
            if (i >= 7) rq = "R9";
            else if (VECS[i].op) rq = "R6";
            else if (VECS[i].xr) rq = "R5";
            else rq = "R4";
            run_vec(VECS[i], i + 1, rq);
        end

        // R8: zero width, then zero height
        load(20);
        wr(3'd0, 32'h0000_0001);
        wr(3'd1, {16'd5, 16'd0});
        wr(3'd7, {16'd3, 16'd3});
        chk(busy == 1'b0, "R8", "busy with zero width", busy, 0);
        wr(3'd0, 32'h6600_0000);
        wr(3'd1, {16'd0, 16'd7});
        wr(3'd7, {16'd3, 16'd3});
        chk(busy == 1'b0, "R8", "busy with zero height", busy, 0);
        repeat (4) @(negedge clk);
        chk(nwr == 0 && nrd == 0, "R8", "accesses for empty rectangle", nwr + nrd, 0);

        // R3: colour write held off during a fill
        load(21);
        wr(3'd0, 32'hCC00_0000);
        wr(3'd1, {16'd2, 16'd8});
        wr(3'd2, 32'(PITCH));
        wr(3'd3, 32'h11);
        wr(3'd5, 32'd0);
        wr(3'd7, {16'd30, 16'd0});
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h22;
        chk(reg_ready == 1'b0, "R2", "ready while busy", reg_ready, 0);
        while (!reg_ready) @(negedge clk);
        @(negedge clk);
        reg_we = 1'b0;
        begin
            int nb;
            nb = 0;
            for (int j = 30; j < 32; j++)
                for (int i = 0; i < 8; i++)
                    if (mem[j * PITCH + i] !== 8'h11) nb++;
            chk(nb == 0, "R3", "pixels keep old colour", nb, 0);
        end
        wr(3'd7, {16'd40, 16'd0});
        wait_idle();
        @(negedge clk);
        begin
            int nb;
            nb = 0;
            for (int i = 0; i < 8; i++)
                if (mem[40 * PITCH + i] !== 8'h22) nb++;
            chk(nb == 0, "R3", "next launch uses new colour", nb, 0);
        end

        chk(hold_err == 0, "R10", "stalled request held", hold_err, 0);
        chk(oob == 0, "R9", "accesses outside bench memory", oob, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule